// File: doc/BRIEF.md
# NOR flash command sequencer

This block is the device-side command decoder of a 16-bit NOR flash emulator. It watches single-cycle bus writes (address, data, write strobe). It recognises unlock-prefixed command sequences and runs the embedded operations they start on a small on-chip word array: word program, sector erase, chip erase, program and erase suspend/resume, and return to read mode. Program and erase durations come from behavioural cycle timers. Each sector of the array has a protect bit.

Reads are registered. While an operation is busy, a read aimed at the operation's scope returns a status word instead of array data. In that word, bit 7 is the complement of the programmed data bit 7 (or 0 for an erase), bit 6 flips on every status read, and bit 3 tells the erase acceptance window (0) apart from the running erase (1). A status-output block downstream uses `busy` together with the two suspend flags.

The command byte is `wdata[7:0]`. The unlock pair is AAh at word address 555h, then 55h at 2AAh. The sector of a word is `addr[MW-1:MW-SB]`.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy`, `ers_susp` and `pgm_susp` are 0 and every word reads FFFFh.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then data@target starts a program. `busy` is high for exactly PGM_CYC cycles. Afterwards the target word holds the old word AND the data.
- R3: The write sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@sector address starts a sector erase. When it completes, every word of the selected unprotected sectors is FFFFh and other sectors are unchanged.
- R4: The same five-write prefix followed by 10h@555h erases every unprotected sector and leaves protected sectors unchanged.
- R5: During the erase acceptance window (WIN_CYC cycles), each further 30h write adds the addressed sector to the erase set and restarts the window. Status bit 3 is 0 inside the window and 1 once erasing runs. Words outside the erase set read as array data.
- R6: B0h written during the acceptance window aborts the erase. `busy` is low after that write and the array is unchanged.
- R7: B0h suspends only a running sector erase (`ers_susp`=1, `busy`=0). It is ignored during a chip erase. 30h resumes only from the erase-suspended state and is ignored in read mode.
- R8: B0h during a running program suspends it (`pgm_susp`=1). 30h resumes it. A further 30h while programming is ignored. A B0h in the cycle right after a resume is ignored.
- R9: Any write that breaks the expected sequence, and F0h at any step before the program data, returns the decoder to read mode, so a following lone data write programs nothing.
- R10: A program aimed at a protected sector keeps `busy` high for PROT_CYC cycles and leaves the array unchanged. Protected sectors are never added to an erase set.
- R11: A status word has upper byte 00h. Bit 7 is the complement of the programmed data bit 7. Bit 6 differs between two consecutive status reads. During a chip erase, addresses in unprotected sectors return status and addresses in protected sectors return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | One bus write per cycle high |
| re | input | 1 | One bus read per cycle high |
| addr | input | AW | Word address for reads and writes |
| wdata | input | 16 | Write data; low byte is the command code |
| prot | input | 2**SB | Per-sector protect bits |
| rdata | output | 16 | Registered read data or status word |
| busy | output | 1 | Embedded operation or acceptance window active |
| ers_susp | output | 1 | Sector erase suspended |
| pgm_susp | output | 1 | Program suspended |

## Verification
The assertions assume that `prot` stays constant while an operation is in progress, because the protected-sector check compares the running program's target against the current protect bits. They also assume that `we` is a single-cycle strobe with stable address and data. The stimulus changes `prot` only while `busy` is low and both suspend flags are clear. It drives each write for exactly one clock edge, with inputs changed on the falling edge.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW       = 12,
  parameter int MW       = 6,
  parameter int SB       = 2,
  parameter int PGM_CYC  = 8,
  parameter int ERS_CYC  = 20,
  parameter int WIN_CYC  = 8,
  parameter int PROT_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 re,
  input  logic [AW-1:0]        addr,
  input  logic [15:0]          wdata,
  input  logic [(1<<SB)-1:0]   prot,
  output logic [15:0]          rdata,
  output logic                 busy,
  output logic                 ers_susp,
  output logic                 pgm_susp
);
  localparam int DEPTH = 1 << MW;
  localparam int NSEC  = 1 << SB;
  localparam int SW    = MW - SB;
  localparam int TMAX  = (ERS_CYC > PGM_CYC) ? ERS_CYC : PGM_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int WW    = $clog2(WIN_CYC + 1);

  typedef enum logic [2:0] {S_RD, S_U1, S_U2, S_PA, S_E1, S_E2, S_EC} seq_t;
  typedef enum logic [2:0] {OP_NONE, OP_PGM, OP_PGM_SUSP, OP_ERS_WIN,
                            OP_ERS, OP_ERS_SUSP, OP_CHIP, OP_PROT} op_t;

  seq_t seq;
  op_t  op;
  logic [15:0]   mem [DEPTH];
  logic [TW-1:0] tmr;
  logic [WW-1:0] wcnt;
  logic [NSEC-1:0] emask;
  logic [MW-1:0] paddr;
  logic [15:0]   pdata;
  logic          sb7, rs_hold, tog;

  wire [7:0]    cmd    = wdata[7:0];
  wire          a555   = addr[11:0] == 12'h555;
  wire          a2aa   = addr[11:0] == 12'h2AA;
  wire [SB-1:0] wsec   = addr[MW-1:SW];
  wire [SB-1:0] psec   = paddr[MW-1:SW];
  wire [NSEC-1:0] secbit = NSEC'(1) << wsec;
  wire          idle_w = we && op == OP_NONE;
  wire          pgm_go = idle_w && seq == S_PA;
  wire          ers_go = idle_w && seq == S_EC && cmd == 8'h30;
  wire          chp_go = idle_w && seq == S_EC && cmd == 8'h10 && a555;
  wire          ers_run = op == OP_ERS || op == OP_CHIP;
  wire          stat_sel = op == OP_PGM || op == OP_PROT ||
                           ((op == OP_ERS_WIN || ers_run) && emask[wsec]);

  assign busy     = op == OP_PGM || op == OP_PROT || op == OP_ERS_WIN || ers_run;
  assign ers_susp = op == OP_ERS_SUSP;
  assign pgm_susp = op == OP_PGM_SUSP;

  always_ff @(posedge clk) begin
    if (!rst_n) seq <= S_RD;
    else if (idle_w) begin
      if (cmd == 8'hF0 && seq != S_PA) seq <= S_RD;
      else case (seq)
        S_RD:    seq <= (a555 && cmd == 8'hAA) ? S_U1 : S_RD;
        S_U1:    seq <= (a2aa && cmd == 8'h55) ? S_U2 : S_RD;
        S_U2:    seq <= (a555 && cmd == 8'hA0) ? S_PA :
                        (a555 && cmd == 8'h80) ? S_E1 : S_RD;
        S_E1:    seq <= (a555 && cmd == 8'hAA) ? S_E2 : S_RD;
        S_E2:    seq <= (a2aa && cmd == 8'h55) ? S_EC : S_RD;
        default: seq <= S_RD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op <= OP_NONE; tmr <= '0; wcnt <= '0; emask <= '0;
      paddr <= '0; pdata <= '0; sb7 <= 1'b0; rs_hold <= 1'b0;
    end else begin
      case (op)
        OP_NONE: begin
          if (pgm_go) begin
            paddr   <= addr[MW-1:0];
            pdata   <= wdata;
            sb7     <= ~wdata[7];
            rs_hold <= 1'b0;
            op      <= prot[wsec] ? OP_PROT : OP_PGM;
            tmr     <= prot[wsec] ? TW'(PROT_CYC - 1) : TW'(PGM_CYC - 1);
          end else if (ers_go) begin
            sb7   <= 1'b0;
            emask <= secbit & ~prot;
            wcnt  <= WW'(WIN_CYC - 1);
            op    <= OP_ERS_WIN;
          end else if (chp_go) begin
            sb7   <= 1'b0;
            emask <= ~prot;
            op    <= (&prot) ? OP_PROT : OP_CHIP;
            tmr   <= (&prot) ? TW'(PROT_CYC - 1) : TW'(ERS_CYC - 1);
          end
        end
        OP_PGM: begin
          if (tmr == '0) op <= OP_NONE;
          else if (we && cmd == 8'hB0 && !rs_hold) op <= OP_PGM_SUSP;
          else begin tmr <= tmr - 1'b1; rs_hold <= 1'b0; end
        end
        OP_PGM_SUSP: if (we && cmd == 8'h30) begin op <= OP_PGM; rs_hold <= 1'b1; end
        OP_ERS_WIN: begin
          if (we && cmd == 8'h30) begin
            emask <= emask | (secbit & ~prot);
            wcnt  <= WW'(WIN_CYC - 1);
          end else if (we && cmd == 8'hB0) begin
            op <= OP_NONE; emask <= '0;
          end else if (wcnt == '0) begin
            op  <= (emask == '0) ? OP_PROT : OP_ERS;
            tmr <= (emask == '0) ? TW'(PROT_CYC - 1) : TW'(ERS_CYC - 1);
          end else wcnt <= wcnt - 1'b1;
        end
        OP_ERS: begin
          if (tmr == '0) begin op <= OP_NONE; emask <= '0; end
          else if (we && cmd == 8'hB0) op <= OP_ERS_SUSP;
          else tmr <= tmr - 1'b1;
        end
        OP_ERS_SUSP: if (we && cmd == 8'h30) op <= OP_ERS;
        default: begin
          if (tmr == '0) begin op <= OP_NONE; emask <= '0; end
          else tmr <= tmr - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else if (tmr == '0) begin
      if (op == OP_PGM) mem[paddr] <= mem[paddr] & pdata;
      if (ers_run)
        for (int i = 0; i < DEPTH; i++)
          if (emask[SB'(i >> SW)]) mem[i] <= 16'hFFFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0; tog <= 1'b0;
    end else if (re) begin
      if (stat_sel) begin
        rdata <= {8'h00, sb7, tog, 2'b00, ers_run, 3'b000};
        tog   <= ~tog;
      end else rdata <= mem[addr[MW-1:0]];
    end
  end

  assert_ers_susp_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ers_susp) |-> $past(op) == OP_ERS);
  assert_chip_no_susp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CHIP) |=> (op == OP_CHIP || op == OP_NONE));
  assert_pgm_susp_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_susp) |-> $past(op == OP_PGM && !rs_hold));
  assert_window_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ERS_WIN && we && cmd == 8'hB0) |=> op == OP_NONE);
  assert_window_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ERS_WIN && we && cmd == 8'h30) |=> (op == OP_ERS_WIN && wcnt == WW'(WIN_CYC - 1)));
  assert_prot_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PGM) |-> !prot[psec]);
endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  prot = '0;
  logic [15:0] rdata;
  logic busy, ers_susp, pgm_susp;
  int total = 0, bad = 0;

  nor_cmd_seq dut (.clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .prot(prot), .rdata(rdata), .busy(busy),
    .ers_susp(ers_susp), .pgm_susp(pgm_susp));

  always #5 clk = ~clk;

  // {address, data, expected word afterwards}
  localparam logic [43:0] VEC [5] = '{
    {12'h001, 16'h1234, 16'h1234},
    {12'h001, 16'hFF00, 16'h1200},
    {12'h012, 16'hA5A5, 16'hA5A5},
    {12'h025, 16'h0F0F, 16'h0F0F},
    {12'h012, 16'h5A5A, 16'h0000}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0; v = rdata;
  endtask

  task automatic prog(input logic [11:0] a, input logic [15:0] d);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic eprefix();
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0080);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, s1, s2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {15'b0, busy}, 16'h0);
    chk("R1 susp", {14'b0, ers_susp, pgm_susp}, 16'h0);
    rd(12'h000, v); chk("R1 word0", v, 16'hFFFF);
    rd(12'h03F, v); chk("R1 word63", v, 16'hFFFF);

    // R2 table of programs
    for (int i = 0; i < 5; i++) begin
      prog(VEC[i][43:32], VEC[i][31:16]);
      wait_idle(n);
      chk("R2 busy cycles", 16'(n), 16'd8);
      rd(VEC[i][43:32], v);
      chk("R2 word", v, VEC[i][15:0]);
    end

    // R11 program status
    prog(12'h030, 16'h0055);
    rd(12'h030, s1); rd(12'h030, s2);
    chk("R11 upper", {8'h0, s1[15:8]}, 16'h0);
    chk("R11 bit7", {15'b0, s1[7]}, 16'h1);
    chk("R11 toggle", {15'b0, s1[6] ^ s2[6]}, 16'h1);
    wait_idle(n);
    rd(12'h030, v); chk("R11 final", v, 16'h0055);

    // R9 broken sequence and F0 reset
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h00AA); wr(12'h555, 16'h00A0); wr(12'h005, 16'h0000);
    chk("R9 deviation busy", {15'b0, busy}, 16'h0);
    rd(12'h005, v); chk("R9 deviation word", v, 16'hFFFF);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h000, 16'h00F0);
    wr(12'h555, 16'h00A0); wr(12'h006, 16'h0000);
    chk("R9 F0 busy", {15'b0, busy}, 16'h0);
    rd(12'h006, v); chk("R9 F0 word", v, 16'hFFFF);

    // R10 protected program
    prot = 4'b1000;
    prog(12'h031, 16'h0000);
    chk("R10 busy", {15'b0, busy}, 16'h1);
    wait_idle(n);
    chk("R10 busy cycles", 16'(n), 16'd3);
    rd(12'h031, v); chk("R10 word", v, 16'hFFFF);

    // R3 R5 sector erase with window additions
    eprefix(); wr(12'h010, 16'h0030);
    wr(12'h020, 16'h0030);
    rd(12'h025, v);
    chk("R5 window status", {v[15:8], 4'h0, v[3], 3'b0}, 16'h0);
    wr(12'h030, 16'h0030);
    rd(12'h001, v); chk("R5 outside set", v, 16'h1200);
    chk("R5 still busy", {15'b0, busy}, 16'h1);
    repeat (10) @(negedge clk);
    rd(12'h025, v);
    chk("R5 erase status", {v[15:8], 4'h0, v[3], 3'b0}, 16'h0008);
    wait_idle(n);
    rd(12'h012, v); chk("R3 sector1", v, 16'hFFFF);
    rd(12'h025, v); chk("R3 sector2", v, 16'hFFFF);
    rd(12'h001, v); chk("R3 sector0 kept", v, 16'h1200);
    rd(12'h030, v); chk("R10 protected kept", v, 16'h0055);

    // R6 abort inside window
    eprefix(); wr(12'h000, 16'h0030); wr(12'h000, 16'h00B0);
    chk("R6 busy", {15'b0, busy}, 16'h0);
    repeat (30) @(negedge clk);
    rd(12'h001, v); chk("R6 word", v, 16'h1200);

    // R7 erase suspend / resume
    wr(12'h000, 16'h0030);
    chk("R7 idle resume ignored", {15'b0, busy}, 16'h0);
    eprefix(); wr(12'h000, 16'h0030);
    repeat (10) @(negedge clk);
    wr(12'h000, 16'h00B0);
    chk("R7 suspended", {14'b0, ers_susp, busy}, 16'h2);
    rd(12'h001, v); chk("R7 not yet erased", v, 16'h1200);
    repeat (30) @(negedge clk);
    chk("R7 stays suspended", {15'b0, ers_susp}, 16'h1);
    wr(12'h000, 16'h0030);
    chk("R7 resumed", {14'b0, ers_susp, busy}, 16'h1);
    wait_idle(n);
    rd(12'h001, v); chk("R7 erased", v, 16'hFFFF);

    // R4 chip erase, suspend ignored
    prog(12'h001, 16'h0001); wait_idle(n);
    eprefix(); wr(12'h555, 16'h0010);
    rd(12'h001, v);
    chk("R11 chip status", {v[15:8], 4'h0, v[3], 3'b0}, 16'h0008);
    rd(12'h030, v); chk("R11 chip protected data", v, 16'h0055);
    wr(12'h000, 16'h00B0);
    chk("R7 chip no suspend", {14'b0, ers_susp, busy}, 16'h1);
    wait_idle(n);
    rd(12'h001, v); chk("R4 erased", v, 16'hFFFF);
    rd(12'h030, v); chk("R4 protected kept", v, 16'h0055);

    // R8 program suspend / resume
    prog(12'h002, 16'h00F0);
    wr(12'h000, 16'h00B0);
    chk("R8 suspended", {14'b0, pgm_susp, busy}, 16'h2);
    rd(12'h002, v); chk("R8 not yet programmed", v, 16'hFFFF);
    wr(12'h000, 16'h0030);
    wr(12'h000, 16'h00B0);
    chk("R8 early suspend ignored", {14'b0, pgm_susp, busy}, 16'h1);
    wr(12'h000, 16'h0030);
    chk("R8 extra resume ignored", {14'b0, pgm_susp, busy}, 16'h1);
    wait_idle(n);
    rd(12'h002, v); chk("R8 programmed", v, 16'h00F0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule